// File: doc/BRIEF.md
# SD Command Issue Controller

This block runs a single command transaction against a register-level host-controller port on behalf of a requester. A request carries a 32-bit opcode word (command index in the low six bits, an application-command marker in bit 31), a response-type code, a flag that marks use of the data lines, a 32-bit argument and a 16-bit block count. The controller checks the inhibit flags, programs the host port in a fixed order, clears all pending status, issues a framed 14-bit command word and then polls the status inputs until the command completes, an error appears or a programmable poll budget runs out.

The result comes back as a one-cycle `done` pulse with a pass/fail bit, the normal status seen when polling stopped, and the response word captured on success. Error bits are cleared by the block before it reports failure, so the host port is left clean for the next request. The bus signalling behind the host port is not part of this block. A testbench can stand in for it.

Host port write addresses: 0 block count, 1 timeout, 2 argument, 3 normal status (write-one-to-clear), 4 error status (write-one-to-clear), 5 command word.

Top module: `sd_cmd_issuer`

## Requirements
- R1: A request accepted while `hc_cmd_inhibit` is high ends with `done` and failure on the next cycle, with no write on the host port and `done_sts` equal to 0.
- R2: Otherwise the first three writes are the block count to address 0 (zero-extended), the timeout code 0x0E to address 1, and the argument to address 2, in that order.
- R3: The next two writes are all-ones of the status width (0xFFFF) to address 3 and then to address 4. Both come before the command word.
- R4: The command word goes to address 5 and is laid out as index in bits 13:8, data-present in bit 5, index check in bit 4 (set when the response code is 2 or 3), CRC check in bit 3 (set when the response code is non-zero), and response code in bits 1:0. Bits 31:14 of that write are zero, so opcode bit 31 never reaches the port.
- R5: The index values 17, 18, 24 and 25 are data commands. They are framed with response code 2 and data-present set, whatever the request says.
- R6: If the framed command uses the data lines and `hc_dat_inhibit` is high when the command word is due, the transaction fails without a command write. A command that does not use the data lines proceeds regardless of `hc_dat_inhibit`.
- R7: While polling, an error (normal status bit 15 or any error status bit) causes one write of 0xFFFF to address 4, then failure with `done_sts` holding the polled normal status.
- R8: When normal status bit 0 (command complete) is seen without error, the block writes 0x0001 to address 3, captures `hc_resp` into `resp`, and reports success with `done_sts` holding the polled status.
- R9: If command complete does not arrive within `poll_limit`+1 polling cycles, the block fails with no further write and `done_sts` equal to 0.
- R10: `busy` is high from the cycle after acceptance until and including the `done` cycle. `done` lasts one cycle, and requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 32 | Opcode word: index in 5:0, application marker in 31 |
| req_rtype | input | 2 | Response code: 0 none, 1 long, 2 short, 3 short with busy |
| req_data | input | 1 | Command uses data lines |
| req_arg | input | 32 | Command argument |
| req_blk_cnt | input | 16 | Block count |
| poll_limit | input | 16 | Polling budget in cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Pass (1) or fail (0), valid with done |
| done_sts | output | 16 | Normal status captured when polling stopped |
| resp | output | 32 | Response captured on success |
| hc_cmd_inhibit | input | 1 | Host command inhibit flag |
| hc_dat_inhibit | input | 1 | Host data inhibit flag |
| hc_norm_sts | input | 16 | Host normal status |
| hc_err_sts | input | 16 | Host error status |
| hc_resp | input | 32 | Host response word |
| hc_wr_en | output | 1 | Host port write strobe |
| hc_wr_addr | output | 3 | Host port write address |
| hc_wr_data | output | 32 | Host port write data |

## Verification
The two guard paths are the hardest to reach. One is the data-inhibit refusal at the moment the command word is due. The other is the poll-budget expiry, which needs a host that never answers. The bench host model takes a per-transaction behaviour (complete, error or silent) and an answer delay. Random transactions mix data-command indices with a raised data inhibit. Directed cases also cover a raised data inhibit on a plain command, a command inhibit at acceptance, and a second request fired into a running transaction.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_BCNT, ST_TMO, ST_ARG, ST_NCLR, ST_ECLR,
      ST_CMD, ST_POLL, ST_EFAIL, ST_CCLR, ST_FIN
   } seq_state_t;

   localparam int          HC_ADDR_W = 3;
   localparam int          CMD_WORD_W = 14;
   localparam logic [2:0]  REG_BCNT = 3'd0;
   localparam logic [2:0]  REG_TMO  = 3'd1;
   localparam logic [2:0]  REG_ARG  = 3'd2;
   localparam logic [2:0]  REG_NSTS = 3'd3;
   localparam logic [2:0]  REG_ESTS = 3'd4;
   localparam logic [2:0]  REG_CMD  = 3'd5;

endpackage

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer #(
   parameter int                     IDX_W   = 6,
   parameter int                     N_DATA  = 4,
   parameter logic [N_DATA*IDX_W-1:0] DATA_IDX = {6'd25, 6'd24, 6'd18, 6'd17}
) (
   input  logic [31:0]                        op_i,
   input  logic [1:0]                         rtype_i,
   input  logic                               data_i,
   output logic [sd_cmd_pkg::CMD_WORD_W-1:0]  word_o,
   output logic                               data_eff_o
);
   localparam logic [1:0] RT_SHORT = 2'd2;

   logic [N_DATA-1:0] hit;
   logic              is_data;
   logic [1:0]        rt;
   logic [31:0]       raw;

   generate
      if (N_DATA < 1 || IDX_W != 6) begin : g_bad
         $error("sd_cmd_framer: need at least one data index of six bits");
      end
      for (genvar k = 0; k < N_DATA; k++) begin : g_hit
         assign hit[k] = (op_i[IDX_W-1:0] == DATA_IDX[k*IDX_W +: IDX_W]);
      end
   endgenerate

   assign is_data    = |hit;
   assign rt         = is_data ? RT_SHORT : rtype_i;
   assign data_eff_o = is_data | data_i;

   always_comb begin
      raw        = '0;
      raw[31]    = op_i[31];
      raw[13:8]  = op_i[IDX_W-1:0];
      raw[5]     = data_eff_o;
      raw[4]     = rt[1];
      raw[3]     = (rt != 2'd0);
      raw[1:0]   = rt;
   end

   assign word_o = raw[sd_cmd_pkg::CMD_WORD_W-1:0];
endmodule

// File: rtl/sd_cmd_poll_timer.sv
module sd_cmd_poll_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);
   logic [W-1:0] cnt;

   generate
      if (W < 2) begin : g_bad
         $error("sd_cmd_poll_timer: width too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run_i)  cnt <= '0;
      else if (cnt != limit_i) cnt <= cnt + 1'b1;
   end

   assign expired_o = run_i && (cnt == limit_i);
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
   parameter int         BLK_W    = 16,
   parameter int         STS_W    = 16,
   parameter int         POLL_W   = 16,
   parameter logic [7:0] TMO_CODE = 8'h0E,
   parameter int         CC_BIT   = 0,
   parameter int         ERR_BIT  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [31:0]       req_op,
   input  logic [1:0]        req_rtype,
   input  logic              req_data,
   input  logic [31:0]       req_arg,
   input  logic [BLK_W-1:0]  req_blk_cnt,
   input  logic [POLL_W-1:0] poll_limit,
   output logic              busy,
   output logic              done,
   output logic              done_ok,
   output logic [STS_W-1:0]  done_sts,
   output logic [31:0]       resp,
   input  logic              hc_cmd_inhibit,
   input  logic              hc_dat_inhibit,
   input  logic [STS_W-1:0]  hc_norm_sts,
   input  logic [STS_W-1:0]  hc_err_sts,
   input  logic [31:0]       hc_resp,
   output logic              hc_wr_en,
   output logic [2:0]        hc_wr_addr,
   output logic [31:0]       hc_wr_data
);
   import sd_cmd_pkg::*;

   localparam logic [31:0] STS_ONES = 32'((64'd1 << STS_W) - 64'd1);
   localparam logic [31:0] CC_MASK  = 32'd1 << CC_BIT;

   generate
      if (STS_W < 2 || STS_W > 31 || CC_BIT >= STS_W || ERR_BIT >= STS_W
          || CC_BIT == ERR_BIT || BLK_W > 32) begin : g_bad
         $error("sd_cmd_issuer: inconsistent width or bit parameters");
      end
   endgenerate

   seq_state_t              state, nstate;
   logic [31:0]             op_q, arg_q;
   logic [1:0]              rt_q;
   logic                    data_q, ok_q;
   logic [BLK_W-1:0]        blk_q;
   logic [CMD_WORD_W-1:0]   cmd_word;
   logic                    data_eff, guard_fail, err_seen, expired;

   sd_cmd_framer u_framer (
      .op_i       (op_q),
      .rtype_i    (rt_q),
      .data_i     (data_q),
      .word_o     (cmd_word),
      .data_eff_o (data_eff)
   );

   sd_cmd_poll_timer #(.W(POLL_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (state == ST_POLL),
      .limit_i   (poll_limit),
      .expired_o (expired)
   );

   assign guard_fail = data_eff && hc_dat_inhibit;
   assign err_seen   = hc_norm_sts[ERR_BIT] || (|hc_err_sts);

   always_comb begin
      nstate = state;
      unique case (state)
         ST_IDLE:  if (req_valid) nstate = hc_cmd_inhibit ? ST_FIN : ST_BCNT;
         ST_BCNT:  nstate = ST_TMO;
         ST_TMO:   nstate = ST_ARG;
         ST_ARG:   nstate = ST_NCLR;
         ST_NCLR:  nstate = ST_ECLR;
         ST_ECLR:  nstate = ST_CMD;
         ST_CMD:   nstate = guard_fail ? ST_FIN : ST_POLL;
         ST_POLL:  if (err_seen)                nstate = ST_EFAIL;
                   else if (hc_norm_sts[CC_BIT]) nstate = ST_CCLR;
                   else if (expired)             nstate = ST_FIN;
         ST_EFAIL: nstate = ST_FIN;
         ST_CCLR:  nstate = ST_FIN;
         ST_FIN:   nstate = ST_IDLE;
         default:  nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_q     <= '0;
         arg_q    <= '0;
         rt_q     <= '0;
         data_q   <= 1'b0;
         blk_q    <= '0;
         ok_q     <= 1'b0;
         done_sts <= '0;
         resp     <= '0;
      end else begin
         state <= nstate;
         if (state == ST_IDLE && req_valid) begin
            op_q     <= req_op;
            arg_q    <= req_arg;
            rt_q     <= req_rtype;
            data_q   <= req_data;
            blk_q    <= req_blk_cnt;
            ok_q     <= 1'b0;
            done_sts <= '0;
         end
         if (state == ST_POLL && (err_seen || hc_norm_sts[CC_BIT]))
            done_sts <= hc_norm_sts;
         if (state == ST_CCLR) begin
            resp <= hc_resp;
            ok_q <= 1'b1;
         end
      end
   end

   always_comb begin
      hc_wr_en   = 1'b1;
      hc_wr_addr = REG_BCNT;
      hc_wr_data = '0;
      unique case (state)
         ST_BCNT:  hc_wr_data = 32'(blk_q);
         ST_TMO:   begin hc_wr_addr = REG_TMO;  hc_wr_data = {24'd0, TMO_CODE}; end
         ST_ARG:   begin hc_wr_addr = REG_ARG;  hc_wr_data = arg_q; end
         ST_NCLR:  begin hc_wr_addr = REG_NSTS; hc_wr_data = STS_ONES; end
         ST_ECLR,
         ST_EFAIL: begin hc_wr_addr = REG_ESTS; hc_wr_data = STS_ONES; end
         ST_CMD:   begin
                      hc_wr_addr = REG_CMD;
                      hc_wr_data = 32'(cmd_word);
                      hc_wr_en   = !guard_fail;
                   end
         ST_CCLR:  begin hc_wr_addr = REG_NSTS; hc_wr_data = CC_MASK; end
         default:  hc_wr_en = 1'b0;
      endcase
   end

   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_FIN);
   assign done_ok = ok_q;
endmodule

// File: rtl/sd_cmd_issuer_chk.sv
module sd_cmd_issuer_chk #(
   parameter int STS_W  = 16,
   parameter int CC_BIT = 0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        hc_cmd_inhibit,
   input logic        busy,
   input logic        done,
   input logic        done_ok,
   input logic        hc_wr_en,
   input logic [2:0]  hc_wr_addr,
   input logic [31:0] hc_wr_data
);
   import sd_cmd_pkg::*;

   localparam logic [31:0] ONES = 32'((64'd1 << STS_W) - 64'd1);

   assert_inhibit_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && hc_cmd_inhibit) |=> (done && !done_ok && !hc_wr_en));

   assert_tmo_follows_bcnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hc_wr_en && hc_wr_addr == REG_BCNT) |=>
         (hc_wr_en && hc_wr_addr == REG_TMO && hc_wr_data == 32'h0E));

   assert_ecl_follows_ncl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hc_wr_en && hc_wr_addr == REG_NSTS && hc_wr_data == ONES) |=>
         (hc_wr_en && hc_wr_addr == REG_ESTS && hc_wr_data == ONES));

   assert_cmd_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hc_wr_en && hc_wr_addr == REG_CMD) |-> (hc_wr_data[31:14] == '0));

   assert_cc_clear_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hc_wr_en && hc_wr_addr == REG_NSTS && hc_wr_data != ONES) |->
         (hc_wr_data == (32'd1 << CC_BIT)) ##1 (done && done_ok));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy ##1 !done);
endmodule

bind sd_cmd_issuer sd_cmd_issuer_chk #(.STS_W(STS_W), .CC_BIT(CC_BIT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .hc_cmd_inhibit (hc_cmd_inhibit),
   .busy           (busy),
   .done           (done),
   .done_ok        (done_ok),
   .hc_wr_en       (hc_wr_en),
   .hc_wr_addr     (hc_wr_addr),
   .hc_wr_data     (hc_wr_data)
);

// File: tb/test_sd_cmd_issuer.sv
module test_sd_cmd_issuer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_op = '0, req_arg = '0;
   logic [1:0]  req_rtype = '0;
   logic        req_data = 1'b0;
   logic [15:0] req_blk_cnt = '0, poll_limit = 16'd10;
   logic        busy, done, done_ok;
   logic [15:0] done_sts;
   logic [31:0] resp;
   logic        hc_cmd_inhibit = 1'b0, hc_dat_inhibit = 1'b0;
   logic [15:0] hc_norm_sts, hc_err_sts;
   logic [31:0] hc_resp = '0;
   logic        hc_wr_en;
   logic [2:0]  hc_wr_addr;
   logic [31:0] hc_wr_data;

   int n_cmp = 0, n_bad = 0;
   int host_mode = 0, host_delay = 0;   // 0 complete, 1 error, 2 silent
   int cd = 0;
   logic armed;

   always #10 clk = ~clk;

   sd_cmd_issuer i_sd_cmd_issuer (.*);

   // emulated host-controller status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc_norm_sts <= '0; hc_err_sts <= '0; armed <= 1'b0; cd <= 0;
      end else if (hc_wr_en) begin
         if (hc_wr_addr == 3'd3) hc_norm_sts <= hc_norm_sts & ~hc_wr_data[15:0];
         if (hc_wr_addr == 3'd4) begin
            hc_err_sts <= hc_err_sts & ~hc_wr_data[15:0];
            if (hc_wr_data[15:0] != 0) hc_norm_sts[15] <= 1'b0;
         end
         if (hc_wr_addr == 3'd5) begin armed <= 1'b1; cd <= host_delay; end
      end else if (armed) begin
         if (cd == 0) begin
            armed <= 1'b0;
            if (host_mode == 0) hc_norm_sts[0] <= 1'b1;
            else if (host_mode == 1) begin hc_err_sts[0] <= 1'b1; hc_norm_sts[15] <= 1'b1; end
         end else cd <= cd - 1;
      end
   end

   task automatic check(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] frame(input logic [31:0] op, input logic [1:0] rt, input logic dp);
      logic isd;
      logic [1:0] r;
      logic d;
      isd = (op[5:0] == 6'd17) || (op[5:0] == 6'd18) || (op[5:0] == 6'd24) || (op[5:0] == 6'd25);
      r = isd ? 2'd2 : rt;
      d = isd | dp;
      return {18'd0, op[5:0], 2'b00, d, r[1], (r != 2'd0), 1'b0, r};
   endfunction

   function automatic logic uses_data(input logic [31:0] op, input logic dp);
      return dp || op[5:0] inside {6'd17, 6'd18, 6'd24, 6'd25};
   endfunction

   task automatic run_txn(input logic [31:0] op, input logic [1:0] rt, input logic dp,
                          input logic [31:0] arg, input logic [15:0] blk, input int mode,
                          input int dly, input logic [15:0] lim, input logic cinh,
                          input logic dinh, input bit poke);
      logic [2:0]  ea[8];
      logic [31:0] ed[8];
      int          en;
      logic [2:0]  la[16];
      logic [31:0] ld[16];
      int          ln, ndone;
      logic        exp_ok, got_ok;
      logic [15:0] exp_sts, got_sts;
      logic [31:0] rv;
      bit          seen;
      en = 0; ln = 0; ndone = 0; exp_ok = 0; exp_sts = 0; seen = 0;
      rv = $urandom;
      got_ok = 0; got_sts = 0;
      if (!cinh) begin
         ea[0] = 3'd0; ed[0] = {16'd0, blk};
         ea[1] = 3'd1; ed[1] = 32'h0E;
         ea[2] = 3'd2; ed[2] = arg;
         ea[3] = 3'd3; ed[3] = 32'hFFFF;
         ea[4] = 3'd4; ed[4] = 32'hFFFF;
         en = 5;
         if (!(uses_data(op, dp) && dinh)) begin
            ea[5] = 3'd5; ed[5] = frame(op, rt, dp); en = 6;
            if (mode == 0) begin ea[6] = 3'd3; ed[6] = 32'h1; en = 7; exp_ok = 1; exp_sts = 16'h0001; end
            else if (mode == 1) begin ea[6] = 3'd4; ed[6] = 32'hFFFF; en = 7; exp_sts = 16'h8000; end
         end
      end
      @(negedge clk);
      host_mode = mode; host_delay = dly; poll_limit = lim;
      hc_cmd_inhibit = cinh; hc_dat_inhibit = dinh; hc_resp = rv;
      req_op = op; req_rtype = rt; req_data = dp; req_arg = arg; req_blk_cnt = blk;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      hc_cmd_inhibit = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (poke && i == 3) begin req_valid = 1'b1; req_op = 32'h5; end
         if (poke && i == 4) req_valid = 1'b0;
         if (hc_wr_en && ln < 16) begin la[ln] = hc_wr_addr; ld[ln] = hc_wr_data; ln++; end
         if (done) begin
            ndone++; got_ok = done_ok; got_sts = done_sts; seen = 1;
            check(busy, "R10 busy with done", 32'(busy), 1);
         end
         @(negedge clk);
         if (seen) begin
            check(!done, "R10 done single cycle", 32'(done), 0);
            break;
         end
      end
      check(ndone == 1, "R10 one done", ndone, 1);
      check(got_ok == exp_ok, cinh ? "R1 inhibit fail" : (mode == 2 ? "R9 poll limit" :
            (mode == 1 ? "R7 error fail" : "R8 pass")), 32'(got_ok), 32'(exp_ok));
      check(got_sts == exp_sts, "R7/R8/R9 status", 32'(got_sts), 32'(exp_sts));
      check(ln == en, cinh ? "R1 no writes" : (dinh ? "R6 write count" : "R3 write count"), ln, en);
      for (int k = 0; k < en && k < ln; k++) begin
         check(la[k] == ea[k], k < 3 ? "R2 address order" : (k < 5 ? "R3 clear address" : "R4 address"),
               32'(la[k]), 32'(ea[k]));
         check(ld[k] == ed[k], k < 3 ? "R2 data" : (k < 5 ? "R3 clear data" :
               (k == 5 ? "R4/R5 command word" : "R7/R8 final write")), ld[k], ed[k]);
      end
      if (exp_ok) check(resp == rv, "R8 response captured", resp, rv);
      check(!busy, "R10 idle after done", 32'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      check(!busy && !done && !hc_wr_en, "R10 reset state", {busy, done, hc_wr_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed: plain command with app marker, pass (R4)
      run_txn(32'h8000_0029, 2'd2, 1'b0, 32'h40300000, 16'd0, 0, 1, 16'd8, 0, 0, 0);
      // data command overriding request fields (R5)
      run_txn(32'd18, 2'd0, 1'b0, 32'h1000, 16'd4, 0, 0, 16'd8, 0, 0, 0);
      // command inhibit at acceptance (R1)
      run_txn(32'd8, 2'd2, 1'b0, 32'h1AA, 16'd0, 0, 0, 16'd8, 1, 0, 0);
      // data inhibit with data command (R6)
      run_txn(32'd25, 2'd2, 1'b0, 32'h2000, 16'd2, 0, 0, 16'd8, 0, 1, 0);
      // data inhibit on plain command is ignored (R6)
      run_txn(32'd0, 2'd0, 1'b0, 32'h0, 16'd0, 0, 2, 16'd8, 0, 1, 0);
      // error during poll (R7)
      run_txn(32'd2, 2'd1, 1'b0, 32'h0, 16'd0, 1, 2, 16'd8, 0, 0, 0);
      // silent host, poll budget runs out (R9)
      run_txn(32'd3, 2'd3, 1'b0, 32'h0, 16'd0, 2, 0, 16'd4, 0, 0, 0);
      // second request while busy is ignored (R10)
      run_txn(32'd7, 2'd3, 1'b0, 32'hABCD0000, 16'd0, 0, 3, 16'd8, 0, 0, 1);
      for (int t = 0; t < 40; t++) begin
         logic [31:0] op;
         int m;
         op = $urandom;
         op[30:6] = $urandom;
         m = $urandom_range(0, 5);
         run_txn(op, 2'($urandom), 1'($urandom), $urandom, 16'($urandom),
                 (m < 3) ? 0 : m - 3, $urandom_range(0, 3), 16'($urandom_range(4, 11)),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) == 0), 0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule